// File: doc/BRIEF.md
# Multiplexed-Bus Program Word Fetch Sequencer

This block reads 16-bit program words from an external memory that shares its low address lines with the data lines. The block runs from a fast clock, with eight ticks to each instruction cycle and two ticks to each quarter of it. A read follows a fixed schedule of ticks. The block drives the 20-bit address, with the low 16 bits on the shared bus and the upper 4 bits on dedicated lines. It pulses the address latch strobe and asserts chip select. It then lets go of the shared lines, pulls the active-low read strobe low for half a cycle, and latches the word as the strobe rises.

A client raises `req` with `addr` while the sequencer is idle. The word appears on `rdata` together with a one-clock `done` pulse. The shared bus is modelled as a split pair: `ad_out` is driven onto the pins while `ad_oe` is high, and `ad_in` carries the sampled pin value. Every strobe is a register output, so no strobe can glitch.

Top module: `mux_fetch_seq`

## Requirements
- R1: After reset, and while idle, `ale`=0, `oe_n`=1, `cs_n`=1, `ad_oe`=0 and `done`=0.
- R2: A request taken while idle starts tick 0 in the next clock. `ale` is 1 in ticks 0 and 1. `ad_out` equals `addr[15:0]` with `ad_oe`=1 from tick 0 through tick 2. `a_hi` equals `addr[19:16]` in every tick from 0 to 7.
- R3: `ale` falls at the start of tick 2. The address stays driven through tick 2, so it is held after the latch edge.
- R4: `ad_oe` drops at the start of tick 3, in the same clock that `oe_n` falls. The strobe never falls while the bus is still driven.
- R5: `oe_n` is low for exactly ticks 3 to 6 (4 ticks) and rises at the start of tick 7.
- R6: `cs_n` is 0 from tick 0 through tick 6, so it leads the `ale` falling edge by 2 ticks. It rises together with `oe_n` at tick 7.
- R7: `rdata` takes the value of `ad_in` from the last clock with `oe_n` low. `done` is 1 for exactly one clock, tick 7, with that value on `rdata`.
- R8: `req` is ignored while a read is in progress. It changes neither the schedule nor the captured word.
- R9: After tick 7 the sequencer is idle for at least one clock before it can accept a request. The bus is therefore driven again no earlier than 2 ticks after `oe_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | tick clock, 8 per instruction cycle |
| rst_n | input | 1 | active-low synchronous reset |
| req | input | 1 | fetch request, sampled while idle |
| addr | input | 20 | word address for the fetch |
| rdata | output | 16 | captured word, valid with done |
| done | output | 1 | one-clock completion pulse |
| ad_in | input | 16 | sampled value of the shared pins |
| ad_out | output | 16 | value driven onto the shared pins |
| ad_oe | output | 1 | drive enable for the shared pins |
| a_hi | output | 4 | upper address lines |
| ale | output | 1 | address latch strobe |
| oe_n | output | 1 | active-low read strobe |
| cs_n | output | 1 | active-low chip select |

## Verification
Directed addresses of all zeros, all ones, and alternating patterns in the upper and low fields show whether the two address parts are routed to the right lines. The memory model returns a word derived from the latched address only while the read strobe is low, and a marker value at all other times. A capture that is one tick early or late therefore reads the marker rather than the data. Random addresses, gaps between requests and stray requests during a read show whether the schedule restarts or the word is disturbed. Back-to-back requests confirm the guard gap before the bus is driven again.

// File: rtl/mux_fetch_seq.sv
module mux_fetch_seq #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int QTR    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic [ADDR_W-1:0]        addr,
  output logic [DATA_W-1:0]        rdata,
  output logic                     done,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     ale,
  output logic                     oe_n,
  output logic                     cs_n
);
  localparam int EIGHTH   = (QTR / 2 > 0) ? QTR / 2 : 1;
  localparam int ALE_FALL = QTR;
  localparam int OE_FALL  = ALE_FALL + EIGHTH;
  localparam int OE_RISE  = OE_FALL + 2 * QTR;
  localparam int LAST     = OE_RISE;
  localparam int CW       = $clog2(LAST + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      ale    <= 1'b0;
      oe_n   <= 1'b1;
      cs_n   <= 1'b1;
      ad_oe  <= 1'b0;
      ad_out <= '0;
      a_hi   <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy   <= 1'b1;
          cnt    <= '0;
          ale    <= 1'b1;
          cs_n   <= 1'b0;
          ad_oe  <= 1'b1;
          ad_out <= addr[DATA_W-1:0];
          a_hi   <= addr[ADDR_W-1:DATA_W];
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(ALE_FALL - 1)) ale <= 1'b0;
        if (cnt == CW'(OE_FALL - 1)) begin
          ad_oe <= 1'b0;
          oe_n  <= 1'b0;
        end
        if (cnt == CW'(OE_RISE - 1)) begin
          oe_n  <= 1'b1;
          cs_n  <= 1'b1;
          rdata <= ad_in;
          done  <= 1'b1;
        end
        if (cnt == CW'(LAST)) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mux_fetch_seq_chk.sv
module mux_fetch_seq_chk #(
  parameter int OE_LEN = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic oe_n,
  input logic cs_n,
  input logic ad_oe,
  input logic done
);
  logic [7:0] lowc;
  always_ff @(posedge clk) begin
    if (!rst_n) lowc <= '0;
    else if (!oe_n) lowc <= lowc + 1'b1;
    else lowc <= '0;
  end

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ad_oe && $past(ad_oe));
  p_release_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !ad_oe);
  p_no_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_oe && !oe_n));
  p_oe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> lowc == 8'(OE_LEN));
  p_cs_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> !cs_n && !$past(cs_n, 2));
  p_cs_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !cs_n);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_at_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> done);
  p_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> oe_n && $past(oe_n));
endmodule

bind mux_fetch_seq mux_fetch_seq_chk #(.OE_LEN(2 * QTR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .oe_n(oe_n),
  .cs_n(cs_n), .ad_oe(ad_oe), .done(done)
);

// File: tb/sim_mux_fetch_seq.sv
`timescale 1ns/1ps
module sim_mux_fetch_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] rdata, ad_in, ad_out;
  logic        done, ad_oe, ale, oe_n, cs_n;
  logic [3:0]  a_hi;
  logic [19:0] lat_addr = '0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mux_fetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .rdata(rdata),
    .done(done), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .a_hi(a_hi), .ale(ale), .oe_n(oe_n), .cs_n(cs_n)
  );

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], a[19:16], 8'h3C} ^ 16'h5A5A;
  endfunction

  always @(negedge ale) lat_addr = {a_hi, ad_out};
  assign ad_in = (!oe_n && !ad_oe) ? mem_word(lat_addr) : 16'hBAD0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fetch(input logic [19:0] a, input bit stray);
    @(negedge clk);
    req = 1'b1; addr = a;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      if (k == 0) req = stray;
      if (stray) addr = $urandom;
      chk(ale == (k < 2), "R2/R3 ale", ale, k < 2);
      chk(ad_oe == (k < 3), "R3/R4 ad_oe", ad_oe, k < 3);
      if (k < 3) chk(ad_out == a[15:0], "R2 ad_out", ad_out, a[15:0]);
      chk(a_hi == a[19:16], "R2 a_hi", a_hi, a[19:16]);
      chk(oe_n == !(k >= 3 && k <= 6), "R5 oe_n", oe_n, !(k >= 3 && k <= 6));
      chk(cs_n == (k == 7), "R6 cs_n", cs_n, k == 7);
      chk(done == (k == 7), "R7 done", done, k == 7);
      if (k == 7) chk(rdata == mem_word(a), "R7/R8 rdata", rdata, mem_word(a));
      if (k == 7) req = 1'b0;
      @(negedge clk);
    end
    chk(!done && !ad_oe && !ale && oe_n && cs_n, "R9 idle after read",
        {done, ad_oe, ale, oe_n, cs_n}, 5'b00011);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D));
    repeat (3) @(negedge clk);
    chk(!ale && oe_n && cs_n && !ad_oe && !done, "R1 reset state",
        {ale, oe_n, cs_n, ad_oe, done}, 5'b01100);
    rst_n = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ale && oe_n && cs_n && !ad_oe, "R1 idle without req",
        {ale, oe_n, cs_n, ad_oe}, 4'b0110);
    fetch(20'h00000, 1'b0);
    fetch(20'hFFFFF, 1'b0);
    fetch(20'hA5555, 1'b0);
    fetch(20'h5AAAA, 1'b1);
    fetch(20'h3C0F1, 1'b0);
    for (int i = 0; i < 40; i++) begin
      int gap = $urandom_range(0, 3);
      repeat (gap) @(negedge clk);
      fetch(20'($urandom), 1'($urandom_range(0, 1)));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule